// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block computes the product C = A x B on a square grid of DIM x DIM multiply-accumulate cells. Every cell owns one entry of C and keeps that entry's running sum in place for the whole job. Operands move between neighbours and not to the sum. An element of A enters at the left edge of its row and shifts one cell to the right each clock. An element of B enters at the top of its column and shifts one cell down each clock. Each input word is therefore taken from outside once and used by DIM cells. Only finished sums leave the grid.

A job starts with a start pulse that also carries the inner dimension K. The caller then presents K beats. Beat k carries column k of A and row k of B, both unskewed, and the block adds the diagonal delays itself. Row r of A is delayed by r cycles and column c of B by c cycles, so A[r][k] and B[k][c] reach cell (r,c) in the same cycle. After the last beat the grid flushes its skew. It then drains the result one row per cycle and raises a done flag. Matrices smaller than the grid are handled by driving zero into the unused lanes.

Top module: `os_matmul`

## Requirements
- R1: For every row r and column c, the drained value equals the sum over k < K of A[r][k]*B[k][c]. Operands are signed 8-bit two's complement and the sum is a 32-bit two's complement value that wraps modulo 2^32.
- R2: A beat is accepted only in a cycle where in_valid_i is high while a job is feeding. Lane r of a_col_i (bits r*8+7..r*8) holds A[r][k] and lane c of b_row_i (bits c*8+7..c*8) holds B[k][c], where k counts the accepted beats from 0. Cycles with in_valid_i low between beats leave the result unchanged.
- R3: A start_i pulse latches K from k_len_i (0..KMAX), zeroes all sums and begins a new job, even while a previous job is draining or done. done_o is low from the cycle after the pulse. K = 0 yields an all-zero result.
- R4: res_valid_o first rises exactly 2*(DIM-1) clock edges after the edge that accepts the final beat, or after the start edge when K = 0. It then stays high for exactly DIM consecutive cycles, with res_idx_o stepping 0, 1, ..., DIM-1. res_row_o carries row res_idx_o, column c at bits c*32+31..c*32.
- R5: done_o rises in the cycle after the last row is drained and stays high, with res_valid_o low, until the next start_i or clear_i.
- R6: A clear_i pulse aborts any job. From the next cycle res_valid_o and done_o are low, and no result appears until a new start_i.
- R7: A product of an M x K matrix by a K x N matrix with M, N < DIM, the unused lanes driven to zero, yields the correct M x N entries and zero in every other entry. This includes the 1 x 1 case.
- R8: in_valid_i and the operand ports are ignored when no job is feeding: while idle, flushing, draining or done.
- R9: While rst_ni is low and after its release, res_valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a job, clear sums, latch K |
| clear_i | input | 1 | Abort the job and return to idle |
| k_len_i | input | $clog2(KMAX+1) | Inner dimension K, sampled with start_i |
| in_valid_i | input | 1 | Beat present on the operand ports |
| a_col_i | input | DIM*8 | One column of A, lane r = row r |
| b_row_i | input | DIM*8 | One row of B, lane c = column c |
| res_valid_o | output | 1 | A result row is on res_row_o |
| res_idx_o | output | max(1,$clog2(DIM)) | Index of the row being drained |
| res_row_o | output | DIM*32 | Result row, lane c = column c |
| done_o | output | 1 | Last row drained |

## Verification
The bench runs many jobs on the default 4 x 4 grid with K from 0 up to the largest allowed value. The operands are random values, the most negative value repeated, and alternating extremes. Each job is run both with back-to-back beats and with gaps between beats. A design with a wrong skew depth pairs A[r][k] with B[k'][c] for k' != k and fails the sums away from row 0 and column 0. A design that accumulates during a gap or during the flush picks up garbage that the bench drives on purpose in every idle cycle. The wait from the last beat to the first valid row is counted exactly, which exposes a drain that starts before the corner cell has its final product. Padded jobs, down to 1 x 1, catch lanes that leak into unused rows. An abort in mid-job must leave no valid row behind.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FEED,
    ST_FLUSH,
    ST_DRAIN,
    ST_DONE
  } mm_state_e;
endpackage

// File: rtl/mm_skew_line.sv
// Fixed delay of DEPTH (>=1) registers, zeroed by clr_i.
module mm_skew_line #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) pipe_q[k] <= '0;
    end else if (clr_i) begin
      for (int k = 0; k < DEPTH; k++) pipe_q[k] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int k = 1; k < DEPTH; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign q_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/mm_mac_cell.sv
// One grid cell: stationary accumulator plus optional operand forwarding.
module mm_mac_cell #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32,
  parameter bit FWD_A  = 1'b1,
  parameter bit FWD_B  = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [DATA_W-1:0] a_o,
  output logic signed [DATA_W-1:0] b_o,
  output logic        [ACC_W-1:0]  acc_o
);
  localparam int PW  = 2 * DATA_W;
  localparam int EXT = ACC_W - PW;

  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0]     prod_ext;

  assign prod     = a_i * b_i;
  assign prod_ext = {{EXT{prod[PW-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else            acc_o <= acc_o + prod_ext;
  end

  if (FWD_A) begin : g_fwd_a
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    a_o <= '0;
      else if (clr_i) a_o <= '0;
      else            a_o <= a_i;
    end
  end else begin : g_end_a
    assign a_o = '0;
  end

  if (FWD_B) begin : g_fwd_b
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    b_o <= '0;
      else if (clr_i) b_o <= '0;
      else            b_o <= b_i;
    end
  end else begin : g_end_b
    assign b_o = '0;
  end
endmodule

// File: rtl/mm_ctrl.sv
// Job sequencer: feed K beats, flush the skew, drain DIM rows.
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int DIM  = 4,
  parameter int KMAX = 16,
  parameter int KW   = 5,
  parameter int IW   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          clear_i,
  input  logic [KW-1:0] k_len_i,
  input  logic          in_valid_i,
  output logic          take_o,
  output logic          clr_o,
  output logic          res_valid_o,
  output logic [IW-1:0] res_idx_o,
  output logic          done_o
);
  localparam int FLUSH_LEN = 2 * (DIM - 1);
  localparam int CW        = $clog2(KMAX + 2 * DIM + 2);
  localparam mm_state_e AFTER_FEED = (FLUSH_LEN == 0) ? ST_DRAIN : ST_FLUSH;

  mm_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] klen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      klen_q  <= '0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      klen_q  <= CW'(k_len_i);
      cnt_q   <= '0;
      state_q <= (k_len_i == '0) ? AFTER_FEED : ST_FEED;
    end else begin
      case (state_q)
        ST_FEED: if (in_valid_i) begin
          if (cnt_q == klen_q - 1'b1) begin
            state_q <= AFTER_FEED;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FLUSH: begin
          if (cnt_q == CW'(FLUSH_LEN - 1)) begin
            state_q <= ST_DRAIN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (cnt_q == CW'(DIM - 1)) begin
            state_q <= ST_DONE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign clr_o       = start_i | clear_i;
  assign take_o      = (state_q == ST_FEED) && in_valid_i && !clr_o;
  assign res_valid_o = (state_q == ST_DRAIN);
  assign res_idx_o   = IW'(cnt_q);
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/os_matmul.sv
module os_matmul #(
  parameter int DIM    = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32,
  parameter int KMAX   = 16,
  localparam int KW    = $clog2(KMAX + 1),
  localparam int IW    = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  clear_i,
  input  logic [KW-1:0]         k_len_i,
  input  logic                  in_valid_i,
  input  logic [DIM*DATA_W-1:0] a_col_i,
  input  logic [DIM*DATA_W-1:0] b_row_i,
  output logic                  res_valid_o,
  output logic [IW-1:0]         res_idx_o,
  output logic [DIM*ACC_W-1:0]  res_row_o,
  output logic                  done_o
);
  logic take, clr;

  // a_in/b_in: operands arriving at cell (r,c); a_nx/b_nx: forwarded copies
  logic signed [DATA_W-1:0] a_in [DIM][DIM];
  logic signed [DATA_W-1:0] b_in [DIM][DIM];
  logic signed [DATA_W-1:0] a_nx [DIM][DIM];
  logic signed [DATA_W-1:0] b_nx [DIM][DIM];
  logic        [ACC_W-1:0]  acc  [DIM][DIM];

  mm_ctrl #(.DIM(DIM), .KMAX(KMAX), .KW(KW), .IW(IW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .k_len_i    (k_len_i),
    .in_valid_i (in_valid_i),
    .take_o     (take),
    .clr_o      (clr),
    .res_valid_o(res_valid_o),
    .res_idx_o  (res_idx_o),
    .done_o     (done_o)
  );

  for (genvar l = 0; l < DIM; l++) begin : g_edge
    logic [DATA_W-1:0] a_gate, b_gate;
    assign a_gate = take ? a_col_i[l*DATA_W +: DATA_W] : '0;
    assign b_gate = take ? b_row_i[l*DATA_W +: DATA_W] : '0;
    if (l == 0) begin : g_direct
      assign a_in[0][0] = a_gate;
      assign b_in[0][0] = b_gate;
    end else begin : g_skew
      mm_skew_line #(.W(DATA_W), .DEPTH(l)) u_a_skew (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .d_i(a_gate), .q_o(a_in[l][0])
      );
      mm_skew_line #(.W(DATA_W), .DEPTH(l)) u_b_skew (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .d_i(b_gate), .q_o(b_in[0][l])
      );
    end
  end

  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      if (c > 0) begin : g_a_link
        assign a_in[r][c] = a_nx[r][c-1];
      end
      if (r > 0) begin : g_b_link
        assign b_in[r][c] = b_nx[r-1][c];
      end
      mm_mac_cell #(
        .DATA_W(DATA_W), .ACC_W(ACC_W),
        .FWD_A (c < DIM - 1), .FWD_B(r < DIM - 1)
      ) u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (clr),
        .a_i   (a_in[r][c]),
        .b_i   (b_in[r][c]),
        .a_o   (a_nx[r][c]),
        .b_o   (b_nx[r][c]),
        .acc_o (acc[r][c])
      );
    end
  end

  always_comb begin
    res_row_o = '0;
    for (int r = 0; r < DIM; r++) begin
      if (res_idx_o == IW'(r)) begin
        for (int c = 0; c < DIM; c++) res_row_o[c*ACC_W +: ACC_W] = acc[r][c];
      end
    end
  end
endmodule

// File: rtl/os_matmul_chk.sv
module os_matmul_chk #(
  parameter int DIM = 4,
  localparam int IW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          clear_i,
  input logic          res_valid_o,
  input logic [IW-1:0] res_idx_o,
  input logic          done_o
);
  // R4
  drain_first_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> res_idx_o == '0);

  // R4
  drain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_idx_o != IW'(DIM - 1) && !start_i && !clear_i)
      |=> res_valid_o && res_idx_o == IW'($past(res_idx_o) + 1'b1));

  // R5
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_idx_o == IW'(DIM - 1) && !start_i && !clear_i)
      |=> done_o && !res_valid_o);

  // R5
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i && !clear_i) |=> done_o && !res_valid_o);

  // R5
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && res_valid_o));

  // R6
  clear_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !res_valid_o && !done_o);

  // R3
  start_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

bind os_matmul os_matmul_chk #(.DIM(DIM)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .clear_i    (clear_i),
  .res_valid_o(res_valid_o),
  .res_idx_o  (res_idx_o),
  .done_o     (done_o)
);

// File: tb/os_matmul_tb.sv
module os_matmul_tb;
  localparam int DIM  = 4;
  localparam int KMAX = 16;
  localparam int KW   = $clog2(KMAX + 1);
  localparam int IW   = $clog2(DIM);
  localparam int F    = 2 * (DIM - 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, clear_i = 1'b0, in_valid_i = 1'b0;
  logic [KW-1:0] k_len_i = '0;
  logic [DIM*8-1:0] a_col_i = '0, b_row_i = '0;
  logic res_valid_o, done_o;
  logic [IW-1:0] res_idx_o;
  logic [DIM*32-1:0] res_row_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int a_m [DIM][KMAX];
  int b_m [KMAX][DIM];

  always #10 clk_i = ~clk_i;

  os_matmul #(.DIM(DIM), .KMAX(KMAX)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .clear_i(clear_i),
    .k_len_i(k_len_i), .in_valid_i(in_valid_i), .a_col_i(a_col_i), .b_row_i(b_row_i),
    .res_valid_o(res_valid_o), .res_idx_o(res_idx_o), .res_row_o(res_row_o), .done_o(done_o)
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic garbage();
    in_valid_i = 1'b1;
    a_col_i = {DIM{8'h5a}} ^ DIM*8'($urandom);
    b_row_i = {DIM{8'ha5}} ^ DIM*8'($urandom);
  endtask

  // mode 0 random, 1 all -128, 2 alternating extremes; m,n = live rows/cols
  task automatic fill(input int mode, input int m, input int n);
    for (int r = 0; r < DIM; r++)
      for (int k = 0; k < KMAX; k++) begin
        a_m[r][k] = (mode == 0) ? $signed(8'($urandom)) : (mode == 1) ? -128 :
                    (((r + k) % 2) ? 127 : -128);
        if (r >= m) a_m[r][k] = 0;
      end
    for (int k = 0; k < KMAX; k++)
      for (int c = 0; c < DIM; c++) begin
        b_m[k][c] = (mode == 0) ? $signed(8'($urandom)) : (mode == 1) ? -128 :
                    (((k + c) % 3) ? -128 : 127);
        if (c >= n) b_m[k][c] = 0;
      end
  endtask

  task automatic run_job(input int k_len, input bit gaps, input string tag);
    int waitc;
    @(negedge clk_i);
    start_i = 1'b1; k_len_i = KW'(k_len);
    @(negedge clk_i);
    start_i = 1'b0;
    // R3: done drops after start
    chk(done_o == 1'b0, {"R3 done low after start ", tag}, done_o, 0);
    for (int k = 0; k < k_len; k++) begin
      if (gaps && (k % 2 == 1)) begin
        in_valid_i = 1'b0;
        a_col_i = '1; b_row_i = '1;
        @(negedge clk_i);
      end
      in_valid_i = 1'b1;
      for (int l = 0; l < DIM; l++) begin
        a_col_i[l*8 +: 8] = 8'(a_m[l][k]);
        b_row_i[l*8 +: 8] = 8'(b_m[k][l]);
      end
      @(negedge clk_i);
    end
    // R8: junk offered during flush and drain must be ignored
    waitc = 0;
    garbage();
    while (!res_valid_o && waitc < 200) begin
      @(negedge clk_i); waitc++; garbage();
    end
    chk(waitc == F, {"R4 drain latency ", tag}, waitc, F);
    for (int r = 0; r < DIM; r++) begin
      chk(res_valid_o && res_idx_o == IW'(r), {"R4 row order ", tag}, res_idx_o, r);
      for (int c = 0; c < DIM; c++) begin
        int exp_v = 0;
        int act_v;
        for (int k = 0; k < k_len; k++) exp_v += a_m[r][k] * b_m[k][c];
        act_v = int'(res_row_o[c*32 +: 32]);
        chk(act_v == exp_v, {"R1/R2/R7 entry ", tag}, act_v, exp_v);
      end
      @(negedge clk_i); garbage();
    end
    chk(done_o && !res_valid_o, {"R5 done after drain ", tag}, done_o, 1);
    for (int h = 0; h < 3; h++) begin
      @(negedge clk_i); garbage();
      chk(done_o && !res_valid_o, {"R5 done held ", tag}, done_o, 1);
    end
    in_valid_i = 1'b0;
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk_i);
    chk(!res_valid_o && !done_o, "R9 in reset", {res_valid_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!res_valid_o && !done_o, "R9 after reset", {res_valid_o, done_o}, 0);
    // R8: junk while idle, then R3 K=0
    repeat (4) begin garbage(); @(negedge clk_i); end
    chk(!res_valid_o && !done_o, "R8 idle junk", res_valid_o, 0);
    in_valid_i = 1'b0;
    fill(0, DIM, DIM);
    run_job(0, 1'b0, "k0");
    // R1/R2 sweeps
    for (int k = 1; k <= KMAX; k++) begin
      fill(0, DIM, DIM);
      run_job(k, 1'b0, "rand");
      fill(0, DIM, DIM);
      run_job(k, 1'b1, "rand_gap");
    end
    fill(1, DIM, DIM); run_job(KMAX, 1'b0, "neg_ext");
    fill(2, DIM, DIM); run_job(KMAX, 1'b1, "alt_ext");
    // R7: padded shapes including 1x1
    fill(0, 1, 1); run_job(1, 1'b0, "pad1x1");
    fill(0, 1, 1); run_job(3, 1'b1, "pad1x1_k3");
    fill(0, 2, 3); run_job(5, 1'b0, "pad2x3");
    fill(0, 3, 1); run_job(2, 1'b1, "pad3x1");
    // R6: abort mid-feed
    fill(0, DIM, DIM);
    @(negedge clk_i);
    start_i = 1'b1; k_len_i = KW'(5);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (2) begin garbage(); @(negedge clk_i); end
    in_valid_i = 1'b0;
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    chk(!res_valid_o && !done_o, "R6 after clear", {res_valid_o, done_o}, 0);
    for (int h = 0; h < 20; h++) begin
      garbage(); @(negedge clk_i);
      chk(!res_valid_o && !done_o, "R6 stays idle", {res_valid_o, done_o}, 0);
    end
    in_valid_i = 1'b0;
    fill(0, DIM, DIM); run_job(6, 1'b1, "after_clear");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule